// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the 8-bit status register of a small 8-bit processor core. It stores three general-purpose output flags, an interrupt-enable bit, an overflow flag and a carry/link flag. Two further bit positions show the synchronized state of two external sense pins. The arithmetic datapath does not write the flags directly. It presents carry, overflow and link results together with a strobe that names the kind of operation: binary add (which also covers complement-and-add), decimal add, or shift/rotate through the link bit. The register selects the flags that each kind of operation may change.

The accumulator can be copied into the register in one cycle, and the full register, including the live sense values, can always be read back. The carry/link bit is returned to the datapath as the carry into bit 0 of the next addition or shift. The user flags drive output pins. When interrupts are enabled, the first sense pin also serves as the interrupt request line.

Top module: `cpu_flag_reg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every writable bit (F0..F2, IE, OV, CY) is 0, `user_flag` is 0, `carry_in` is 0 and `irq_req` is 0.
- R2: The read value `stat_rd` has this layout: bit0 F0, bit1 F1, bit2 F2, bit3 IE, bit4 SA, bit5 SB, bit6 OV, bit7 CY. A cycle with `acc_wr`=1 loads bits 0-3, 6 and 7 from `acc_data`, and the new value shows on the next cycle.
- R3: `user_flag[2:0]` always equals register bits 2:0.
- R4: Bits 4 and 5 come only from `sense_a_pin` and `sense_b_pin`, passed through a two-flop synchronizer, so a pin value appears two rising edges after it is sampled. An accumulator write has no effect on these bits.
- R5: `irq_req` is 1 exactly when IE is 1 and the synchronized SA is 1. With IE at 0 the sense A pin never raises `irq_req`.
- R6: A binary-add strobe (`bin_en`) loads CY from `bin_carry` and OV from `bin_ovf`.
- R7: A decimal-add strobe (`dec_en`) loads CY from `dec_carry` and leaves OV unchanged.
- R8: A shift/rotate strobe (`shr_en`) loads CY from `shr_link` and leaves OV unchanged.
- R9: `carry_in` always equals the stored CY bit.
- R10: When `acc_wr` is 1 in the same cycle as any arithmetic strobe, the accumulator write decides every writable bit.
- R11: When several arithmetic strobes are 1 together, binary add wins over decimal add, and decimal add wins over shift/rotate.
- R12: In a cycle with no write and no strobe, F0..F2, IE, OV and CY hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Copy accumulator into register |
| acc_data | input | 8 | Accumulator value to copy |
| bin_en | input | 1 | Binary add / complement-and-add result strobe |
| bin_carry | input | 1 | Carry out of bit 7 from binary add |
| bin_ovf | input | 1 | Signed overflow from binary add |
| dec_en | input | 1 | Decimal add result strobe |
| dec_carry | input | 1 | Carry out of decimal add |
| shr_en | input | 1 | Shift/rotate-through-link strobe |
| shr_link | input | 1 | New link value from shift/rotate |
| sense_a_pin | input | 1 | External sense A / interrupt pin |
| sense_b_pin | input | 1 | External sense B pin |
| stat_rd | output | 8 | Register read value |
| user_flag | output | 3 | User flag output pins F2..F0 |
| carry_in | output | 1 | CY/L fed back to the datapath |
| irq_req | output | 1 | Interrupt request |

## Verification
Every stored bit reaches a port directly through `stat_rd`, `user_flag` or `carry_in`. A wrong flag update therefore shows on the cycle right after the write or strobe that caused it. A sense path with the wrong number of stages shifts the pin's value on `stat_rd` and `irq_req` by one cycle, and a bench that tracks the two-edge delay every cycle exposes that at once. An OV bit that a decimal add or shift corrupts shows on the next read. Because OV only changes again on a binary add or a write, the wrong value then stays visible.

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_wr,
  input  logic [7:0] acc_data,
  input  logic       bin_en,
  input  logic       bin_carry,
  input  logic       bin_ovf,
  input  logic       dec_en,
  input  logic       dec_carry,
  input  logic       shr_en,
  input  logic       shr_link,
  input  logic       sense_a_pin,
  input  logic       sense_b_pin,
  output logic [7:0] stat_rd,
  output logic [2:0] user_flag,
  output logic       carry_in,
  output logic       irq_req
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [2:0]   uf_q;
  logic         ie_q, ov_q, cy_q;
  logic [TOP:0] sa_sync, sb_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q    <= '0;
      ie_q    <= 1'b0;
      ov_q    <= 1'b0;
      cy_q    <= 1'b0;
      sa_sync <= '0;
      sb_sync <= '0;
    end else begin
      sa_sync <= {sa_sync[TOP-1:0], sense_a_pin};
      sb_sync <= {sb_sync[TOP-1:0], sense_b_pin};
      if (acc_wr) begin
        uf_q <= acc_data[2:0];
        ie_q <= acc_data[3];
        ov_q <= acc_data[6];
        cy_q <= acc_data[7];
      end else if (bin_en) begin
        cy_q <= bin_carry;
        ov_q <= bin_ovf;
      end else if (dec_en) begin
        cy_q <= dec_carry;
      end else if (shr_en) begin
        cy_q <= shr_link;
      end
    end
  end

  assign stat_rd   = {cy_q, ov_q, sb_sync[TOP], sa_sync[TOP], ie_q, uf_q};
  assign user_flag = uf_q;
  assign carry_in  = cy_q;
  assign irq_req   = ie_q & sa_sync[TOP];
endmodule

// File: rtl/cpu_flag_reg_chk.sv
module cpu_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_wr,
  input logic [7:0] acc_data,
  input logic       bin_en,
  input logic       bin_carry,
  input logic       bin_ovf,
  input logic       dec_en,
  input logic       shr_en,
  input logic [7:0] stat_rd,
  input logic       irq_req
);
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> (stat_rd[7:6] == $past(acc_data[7:6])) && (stat_rd[3:0] == $past(acc_data[3:0])));

  a_r6_bin_update: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_en && !acc_wr) |=> (stat_rd[7] == $past(bin_carry)) && (stat_rd[6] == $past(bin_ovf)));

  a_r7_dec_keeps_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !bin_en && !acc_wr) |=> $stable(stat_rd[6]));

  a_r8_shift_keeps_ov: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_en && !dec_en && !bin_en && !acc_wr) |=> $stable(stat_rd[6]));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wr && !bin_en && !dec_en && !shr_en) |=> ($stable(stat_rd[7:6]) && $stable(stat_rd[3:0])));

  a_r5_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (stat_rd[3] && stat_rd[4]));
endmodule

bind cpu_flag_reg cpu_flag_reg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_data(acc_data),
  .bin_en(bin_en), .bin_carry(bin_carry), .bin_ovf(bin_ovf),
  .dec_en(dec_en), .shr_en(shr_en), .stat_rd(stat_rd), .irq_req(irq_req)
);

// File: tb/cpu_flag_reg_tb_top.sv
`timescale 1ns/1ps
module cpu_flag_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_wr = 0, bin_en = 0, bin_carry = 0, bin_ovf = 0;
  logic dec_en = 0, dec_carry = 0, shr_en = 0, shr_link = 0;
  logic sense_a_pin = 0, sense_b_pin = 0;
  logic [7:0] acc_data = '0;
  logic [7:0] stat_rd;
  logic [2:0] user_flag;
  logic carry_in, irq_req;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0] m_uf;
  logic m_ie, m_ov, m_cy, m_sa1, m_sa2, m_sb1, m_sb2;

  always #10 clk = ~clk;

  cpu_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_data(acc_data),
    .bin_en(bin_en), .bin_carry(bin_carry), .bin_ovf(bin_ovf),
    .dec_en(dec_en), .dec_carry(dec_carry), .shr_en(shr_en), .shr_link(shr_link),
    .sense_a_pin(sense_a_pin), .sense_b_pin(sense_b_pin),
    .stat_rd(stat_rd), .user_flag(user_flag), .carry_in(carry_in), .irq_req(irq_req)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = {m_cy, m_ov, m_sb2, m_sa2, m_ie, m_uf};
    chk(stat_rd == e, "R2 R4 R6 R7 R8 R10 R11 R12 stat_rd", stat_rd, e);
    chk(user_flag == m_uf, "R3 user_flag", {5'd0, user_flag}, {5'd0, m_uf});
    chk(carry_in == m_cy, "R9 carry_in", {7'd0, carry_in}, {7'd0, m_cy});
    chk(irq_req == (m_ie & m_sa2), "R5 irq_req", {7'd0, irq_req}, {7'd0, m_ie & m_sa2});
  endtask

  task automatic step();
    @(posedge clk);
    m_sa2 = m_sa1; m_sa1 = sense_a_pin;
    m_sb2 = m_sb1; m_sb1 = sense_b_pin;
    if (acc_wr) begin
      m_uf = acc_data[2:0]; m_ie = acc_data[3]; m_ov = acc_data[6]; m_cy = acc_data[7];
    end else if (bin_en) begin
      m_cy = bin_carry; m_ov = bin_ovf;
    end else if (dec_en) m_cy = dec_carry;
    else if (shr_en) m_cy = shr_link;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    logic [15:0] lfsr;
    m_uf = 0; m_ie = 0; m_ov = 0; m_cy = 0;
    m_sa1 = 0; m_sa2 = 0; m_sb1 = 0; m_sb2 = 0;
    sense_a_pin = 1; sense_b_pin = 1;
    repeat (3) @(negedge clk);
    chk(stat_rd == 8'h00 && user_flag == 0 && !irq_req && !carry_in, "R1 reset", stat_rd, 8'h00);
    sense_a_pin = 0; sense_b_pin = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(stat_rd == 8'h00 && !irq_req, "R1 after reset", stat_rd, 8'h00);
    // R2 R4: every accumulator value, sense pins held high so bits 4,5 must not follow acc_data
    sense_a_pin = 1; sense_b_pin = 1;
    for (int v = 0; v < 256; v++) begin
      acc_wr = 1; acc_data = v[7:0];
      step();
    end
    acc_wr = 0;
    // R5 R4: sense pin sweep with IE both ways
    for (int k = 0; k < 16; k++) begin
      acc_wr = 1; acc_data = {4'b0, k[3], 3'b0};
      sense_a_pin = k[0]; sense_b_pin = k[1];
      step();
      acc_wr = 0; sense_a_pin = k[2]; sense_b_pin = ~k[2];
      step(); step(); step();
    end
    // R6 R7 R8 R10 R11 R12: exhaustive strobe/result combinations, then pseudo-random mix
    for (int c = 0; c < 256; c++) begin
      acc_wr = 1; acc_data = 8'h40; step();
      acc_wr = c[0]; acc_data = {c[7], c[1], 6'h2A};
      bin_en = c[1]; bin_carry = c[2]; bin_ovf = c[3];
      dec_en = c[4]; dec_carry = ~c[2];
      shr_en = c[5]; shr_link = c[6];
      sense_a_pin = c[7];
      step();
      acc_wr = 0; bin_en = 0; dec_en = 0; shr_en = 0;
      step();
    end
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc_wr = (lfsr[2:0] == 0); acc_data = lfsr[15:8];
      bin_en = lfsr[3]; bin_carry = lfsr[4]; bin_ovf = lfsr[5];
      dec_en = lfsr[6]; dec_carry = lfsr[7]; shr_en = lfsr[8]; shr_link = lfsr[9];
      sense_a_pin = lfsr[10]; sense_b_pin = lfsr[11];
      step();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule